// File: doc/BRIEF.md
# Debug Monitor Boot and Host Handshake Controller

This block makes the boot decision for a device that can start either in a built-in debug monitor or in normal user code. On the first clock edge after the active-low reset is released it samples two conditions: a flag that reports a high test voltage on the interrupt pin, and the two bytes of the reset vector read from memory. If either condition calls for the monitor, the block enters monitor mode. It then holds that choice until the next reset, whatever the inputs do afterwards. The block also drives the watchdog-disable signal, the page used for exception vector fetches, and a latched copy of the clock-divisor select pin.

In monitor mode the block runs the opening handshake with a host. It counts eight security bytes delivered by an external serial receiver and compares them in order against a key input. It then drives a break on the serial transmit line: the line is held low for ten bit-rate ticks, which the host uses to measure the baud rate. After the break the line returns high and the block raises a ready-for-command flag. In user mode the transmit line stays idle and the handshake never starts.

Top module: `mon_entry_ctrl`

## Requirements
- R1: The boot decision is taken on the first rising clock edge after `rst_ni` goes high. After that, `mon_mode_o` and `div_sel_o` keep their values until the next reset, even if `hv_irq_i`, `vec_hi_i`, `vec_lo_i` or `div_sel_i` change.
- R2: Monitor mode is selected when `hv_irq_i` is 1, or when both `vec_hi_i` and `vec_lo_i` equal 8'hFF (the erased value). Otherwise user mode is selected and `mon_mode_o` stays 0.
- R3: The value of `wdog_dis_o` depends on how the block booted:
  - After a blank-vector entry, it is 1 whatever `hv_irq_i` does.
  - After an entry caused only by the test voltage, it follows the live value of `hv_irq_i`.
  - In user mode, it is 0.
- R4: `div_sel_o` holds the value of `div_sel_i` captured at the decision, but only when `hv_irq_i` was 1 at that moment. In every other case it is 0.
- R5: In monitor mode, only cycles with `rx_valid_i` high count as security bytes. While fewer than eight have arrived, `tx_o` stays 1 and `cmd_ready_o` stays 0, ticks included.
- R6: The break works as follows:
  - It starts on the cycle after the eighth security byte is accepted: `tx_o` goes 0.
  - It lasts exactly 10 `tick_i` pulses.
  - The 10th tick returns `tx_o` to 1 and sets `cmd_ready_o` to 1.
  - `cmd_ready_o` then stays 1 until reset.
- R7: Security byte k (k = 0 first) is compared with `key_i[8k+7:8k]`. `sec_pass_o` is 1 after the eighth byte only if all eight bytes match. The break is sent either way. Bytes received after the eighth change nothing.
- R8: `vec_page_o` is 8'hFE in monitor mode and 8'hFF otherwise.
- R9: In user mode, `tx_o` stays 1 and `cmd_ready_o` stays 0, whatever bytes or ticks arrive.
- R10: While `rst_ni` is low, the outputs take these values:
  - `mon_mode_o`, `wdog_dis_o`, `div_sel_o`, `cmd_ready_o` and `sec_pass_o` are 0.
  - `tx_o` is 1.
  - `vec_page_o` is 8'hFF.
  
  A reset during the handshake discards any partial byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hv_irq_i | input | 1 | High test voltage present on the interrupt pin |
| vec_hi_i | input | 8 | Reset vector byte at FFFE |
| vec_lo_i | input | 8 | Reset vector byte at FFFF |
| div_sel_i | input | 1 | Clock-divisor select pin |
| key_i | input | 64 | Security key; byte k in bits 8k+7:8k |
| rx_valid_i | input | 1 | Received-byte strobe from the serial receiver |
| rx_data_i | input | 8 | Received byte |
| tick_i | input | 1 | One pulse per serial bit time |
| mon_mode_o | output | 1 | Monitor mode latched |
| wdog_dis_o | output | 1 | Watchdog disable |
| vec_page_o | output | 8 | Page for vector fetches (reset, SWI, break) |
| div_sel_o | output | 1 | Divisor select in effect |
| tx_o | output | 1 | Serial transmit line, idle high |
| cmd_ready_o | output | 1 | Monitor ready for commands |
| sec_pass_o | output | 1 | All security bytes matched |

## Verification
The assertions check these properties on every cycle:
- The latched mode stays stable after the decision.
- Every low period on the transmit line spans exactly ten ticks.
- The ready flag implies the monitor vector page, and once raised it never drops.
- A user-mode boot keeps the line idle and never signals ready.
- The watchdog is never disabled outside monitor mode.

The assertions cannot judge whether a given vector and voltage combination should have produced monitor mode. Nor can they judge whether a key comparison result is right, whether a byte count was discarded by a mid-handshake reset, or whether the divisor select was captured properly. Only the bench's sweeps over entry conditions, mismatch positions and reset timing show those.

// File: rtl/mon_pkg.sv
package mon_pkg;
  typedef enum logic [2:0] {
    ST_DECIDE,
    ST_USER,
    ST_WAIT,
    ST_BREAK,
    ST_READY
  } mon_state_e;
endpackage

// File: rtl/mon_entry_decide.sv
module mon_entry_decide #(
  parameter int          DATA_W = 8,
  parameter logic [7:0]  ERASED = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              hv_i,
  input  logic [DATA_W-1:0] vec_hi_i,
  input  logic [DATA_W-1:0] vec_lo_i,
  input  logic              div_sel_i,
  output logic              enter_o,
  output logic              mon_o,
  output logic              blank_o,
  output logic              div_sel_o
);
  logic blank;

  assign blank   = (vec_hi_i == DATA_W'(ERASED)) && (vec_lo_i == DATA_W'(ERASED));
  assign enter_o = hv_i | blank;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mon_o     <= 1'b0;
      blank_o   <= 1'b0;
      div_sel_o <= 1'b0;
    end else if (sample_i) begin
      mon_o     <= enter_o;
      blank_o   <= blank;
      div_sel_o <= hv_i & div_sel_i; // pin honoured only with test voltage
    end
  end
endmodule

// File: rtl/mon_sec_check.sv
module mon_sec_check #(
  parameter int DATA_W    = 8,
  parameter int SEC_BYTES = 8,
  localparam int CW       = (SEC_BYTES > 1) ? $clog2(SEC_BYTES) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        en_i,
  input  logic                        rx_valid_i,
  input  logic [DATA_W-1:0]           rx_data_i,
  input  logic [SEC_BYTES*DATA_W-1:0] key_i,
  output logic                        done_o,
  output logic                        pass_o
);
  logic [CW-1:0]     cnt_q;
  logic              ok_q;
  logic [DATA_W-1:0] key_byte;
  logic              hit, take;

  assign key_byte = key_i[cnt_q*DATA_W +: DATA_W];
  assign hit      = (rx_data_i == key_byte);
  assign take     = en_i & rx_valid_i;
  assign done_o   = take && (cnt_q == CW'(SEC_BYTES-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      ok_q   <= 1'b1;
      pass_o <= 1'b0;
    end else if (take) begin
      if (done_o) begin
        cnt_q  <= '0;
        pass_o <= ok_q & hit;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        ok_q   <= ok_q & hit;
      end
    end
  end
endmodule

// File: rtl/mon_break_gen.sv
module mon_break_gen #(
  parameter int BREAK_BITS = 10,
  localparam int CW        = (BREAK_BITS > 1) ? $clog2(BREAK_BITS) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  output logic done_o
);
  logic [CW-1:0] cnt_q;

  assign done_o = en_i && tick_i && (cnt_q == CW'(BREAK_BITS-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!en_i || done_o)  cnt_q <= '0;
    else if (tick_i)           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mon_entry_ctrl.sv
module mon_entry_ctrl
  import mon_pkg::*;
#(
  parameter int         DATA_W     = 8,
  parameter int         SEC_BYTES  = 8,
  parameter int         BREAK_BITS = 10,
  parameter logic [7:0] ERASED     = 8'hFF,
  parameter logic [7:0] PAGE_MON   = 8'hFE,
  parameter logic [7:0] PAGE_USR   = 8'hFF,
  localparam int        KEY_W      = SEC_BYTES * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hv_irq_i,
  input  logic [DATA_W-1:0] vec_hi_i,
  input  logic [DATA_W-1:0] vec_lo_i,
  input  logic              div_sel_i,
  input  logic [KEY_W-1:0]  key_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              tick_i,
  output logic              mon_mode_o,
  output logic              wdog_dis_o,
  output logic [7:0]        vec_page_o,
  output logic              div_sel_o,
  output logic              tx_o,
  output logic              cmd_ready_o,
  output logic              sec_pass_o
);
  mon_state_e state_q, state_d;
  logic enter, blank_q, sec_done, brk_done;

  mon_entry_decide #(.DATA_W(DATA_W), .ERASED(ERASED)) u_decide (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sample_i  (state_q == ST_DECIDE),
    .hv_i      (hv_irq_i),
    .vec_hi_i  (vec_hi_i),
    .vec_lo_i  (vec_lo_i),
    .div_sel_i (div_sel_i),
    .enter_o   (enter),
    .mon_o     (mon_mode_o),
    .blank_o   (blank_q),
    .div_sel_o (div_sel_o)
  );

  mon_sec_check #(.DATA_W(DATA_W), .SEC_BYTES(SEC_BYTES)) u_sec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (state_q == ST_WAIT),
    .rx_valid_i (rx_valid_i),
    .rx_data_i  (rx_data_i),
    .key_i      (key_i),
    .done_o     (sec_done),
    .pass_o     (sec_pass_o)
  );

  mon_break_gen #(.BREAK_BITS(BREAK_BITS)) u_brk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == ST_BREAK),
    .tick_i (tick_i),
    .done_o (brk_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_DECIDE: state_d = enter ? ST_WAIT : ST_USER;
      ST_WAIT:   if (sec_done) state_d = ST_BREAK;
      ST_BREAK:  if (brk_done) state_d = ST_READY;
      default:   state_d = state_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_DECIDE;
    else         state_q <= state_d;
  end

  // blank-vector entry keeps the watchdog off; test-voltage entry only while held
  assign wdog_dis_o  = mon_mode_o & (blank_q | hv_irq_i);
  assign vec_page_o  = mon_mode_o ? PAGE_MON : PAGE_USR;
  assign tx_o        = (state_q != ST_BREAK);
  assign cmd_ready_o = (state_q == ST_READY);
endmodule

// File: rtl/mon_entry_chk.sv
module mon_entry_chk #(
  parameter int BREAK_BITS = 10
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       mon_mode_o,
  input logic       wdog_dis_o,
  input logic [7:0] vec_page_o,
  input logic       tx_o,
  input logic       cmd_ready_o
);
  logic        decided_q;
  logic [15:0] low_ticks_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      decided_q   <= 1'b0;
      low_ticks_q <= '0;
    end else begin
      decided_q <= 1'b1;
      if (!tx_o && tick_i) low_ticks_q <= low_ticks_q + 1'b1;
      else if (tx_o)       low_ticks_q <= '0;
    end
  end

  AST_MODE_LATCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decided_q |=> $stable(mon_mode_o)); // R1
  AST_NO_WDOG_USER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mon_mode_o |-> !wdog_dis_o); // R3
  AST_BREAK_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_o) |-> (low_ticks_q == 16'(BREAK_BITS))); // R6
  AST_READY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |=> cmd_ready_o); // R6
  AST_READY_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> (mon_mode_o && vec_page_o == 8'hFE)); // R8
  AST_USER_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decided_q && !mon_mode_o) |-> (tx_o && !cmd_ready_o)); // R9
endmodule

bind mon_entry_ctrl mon_entry_chk #(.BREAK_BITS(BREAK_BITS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .mon_mode_o  (mon_mode_o),
  .wdog_dis_o  (wdog_dis_o),
  .vec_page_o  (vec_page_o),
  .tx_o        (tx_o),
  .cmd_ready_o (cmd_ready_o)
);

// File: tb/sim_mon_entry_ctrl.sv
module sim_mon_entry_ctrl;
  localparam int CLK_P = 10;
  localparam logic [63:0] KEY = 64'h0123_4567_89AB_CDEF;

  logic clk = 1'b0, rst_ni = 1'b0, hv = 1'b0, div_sel = 1'b0;
  logic [7:0] vhi = 8'h00, vlo = 8'h00, rxd = 8'h00;
  logic rxv = 1'b0, tick = 1'b0;
  logic mon, wdog, divo, tx, rdy, pass;
  logic [7:0] page;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  mon_entry_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .hv_irq_i(hv), .vec_hi_i(vhi), .vec_lo_i(vlo),
    .div_sel_i(div_sel), .key_i(KEY), .rx_valid_i(rxv), .rx_data_i(rxd), .tick_i(tick),
    .mon_mode_o(mon), .wdog_dis_o(wdog), .vec_page_o(page), .div_sel_o(divo),
    .tx_o(tx), .cmd_ready_o(rdy), .sec_pass_o(pass)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    rxv = 1'b1; rxd = b;
    @(negedge clk);
    rxv = 1'b0; rxd = ~b; // garbage while strobe low
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset(input logic h, input logic [7:0] hi, input logic [7:0] lo, input logic ds);
    @(negedge clk);
    rst_ni = 1'b0; hv = h; vhi = hi; vlo = lo; div_sel = ds;
    @(negedge clk);
    // R10 reset state
    chk("R10 mon", int'(mon), 0); chk("R10 tx", int'(tx), 1);
    chk("R10 rdy", int'(rdy), 0); chk("R10 page", int'(page), 8'hFF);
    chk("R10 wdog", int'(wdog), 0); chk("R10 pass", int'(pass), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk); // first edge after release took the decision
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [7:0] hi_tab [4];
    logic [7:0] lo_tab [4];
    hi_tab[0] = 8'hFF; lo_tab[0] = 8'hFF;
    hi_tab[1] = 8'hFF; lo_tab[1] = 8'hFE;
    hi_tab[2] = 8'h7F; lo_tab[2] = 8'hFF;
    hi_tab[3] = 8'h12; lo_tab[3] = 8'h34;
    repeat (2) @(negedge clk);

    for (int h = 0; h < 2; h++) begin
      for (int v = 0; v < 4; v++) begin
        for (int ds = 0; ds < 2; ds++) begin
          logic blank, exp_mon, exp_pass;
          int bad;
          blank   = (hi_tab[v] == 8'hFF) && (lo_tab[v] == 8'hFF);
          exp_mon = (h != 0) || blank;
          do_reset(h[0], hi_tab[v], lo_tab[v], ds[0]);
          chk("R2 mon", int'(mon), int'(exp_mon));
          chk("R8 page", int'(page), exp_mon ? 8'hFE : 8'hFF);
          chk("R3 wdog", int'(wdog), int'(exp_mon));
          chk("R4 div", int'(divo), int'((h != 0) && (ds != 0)));
          // change entry pins after decision
          hv = ~hv; vhi = ~vhi; vlo = ~vlo; div_sel = ~div_sel;
          @(negedge clk);
          chk("R1 mon held", int'(mon), int'(exp_mon));
          chk("R1 div held", int'(divo), int'((h != 0) && (ds != 0)));
          chk("R3 wdog live", int'(wdog), int'(exp_mon && (blank || hv)));
          hv = ~hv;
          @(negedge clk);
          chk("R3 wdog back", int'(wdog), int'(exp_mon && (blank || hv)));

          bad = (h * 8 + v * 2 + ds) % 3 == 0 ? -1 : (v * 2 + ds);
          exp_pass = (bad < 0);
          for (int k = 0; k < 8; k++) begin
            logic [7:0] b;
            b = KEY[8*k +: 8];
            if (k == bad) b = b ^ 8'h40;
            if (k == 7) begin
              chk("R5 tx before 8th", int'(tx), 1);
              chk("R5 rdy before 8th", int'(rdy), 0);
              pulse_tick();
              chk("R5 tick ignored in wait", int'(tx), 1);
            end
            send_byte(b);
          end
          if (!exp_mon) begin
            repeat (12) pulse_tick();
            chk("R9 user tx", int'(tx), 1);
            chk("R9 user rdy", int'(rdy), 0);
            chk("R9 user pass", int'(pass), 0);
          end else begin
            chk("R6 break start", int'(tx), 0);
            for (int t = 1; t <= 10; t++) begin
              pulse_tick();
              if (t < 10) chk("R6 break hold", int'(tx), 0);
            end
            chk("R6 tx idle", int'(tx), 1);
            chk("R6 ready", int'(rdy), 1);
            chk("R7 pass", int'(pass), int'(exp_pass));
            send_byte(KEY[7:0]);
            pulse_tick();
            chk("R7 extra byte pass", int'(pass), int'(exp_pass));
            chk("R6 ready sticky", int'(rdy), 1);
            chk("R8 page mon", int'(page), 8'hFE);
          end
        end
      end
    end

    // R10: reset mid-handshake discards the partial count
    do_reset(1'b0, 8'hFF, 8'hFF, 1'b0);
    for (int k = 0; k < 3; k++) send_byte(KEY[8*k +: 8]);
    do_reset(1'b0, 8'hFF, 8'hFF, 1'b0);
    chk("R10 mon after re-reset", int'(mon), 1);
    for (int k = 0; k < 5; k++) send_byte(KEY[8*k +: 8]);
    chk("R10 count restarted", int'(tx), 1);
    for (int k = 5; k < 8; k++) send_byte(KEY[8*k +: 8]);
    chk("R10 break after 8", int'(tx), 0);
    repeat (10) pulse_tick();
    chk("R10 ready", int'(rdy), 1);
    chk("R10 pass", int'(pass), 1);

    // reset during break
    do_reset(1'b1, 8'h00, 8'h00, 1'b1);
    for (int k = 0; k < 8; k++) send_byte(KEY[8*k +: 8]);
    repeat (4) pulse_tick();
    chk("R6 mid break", int'(tx), 0);
    do_reset(1'b0, 8'h00, 8'h00, 1'b0);
    chk("R2 user after reset", int'(mon), 0);
    chk("R9 tx idle", int'(tx), 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule